// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a 32-bit effective address to a real address by searching a hashed page table held in memory. It is used after the block-translation check has missed. The caller presents one request together with the segment register value already chosen for the address, the table-origin/size register, and three flags: write access, instruction fetch, and user privilege. From these the block derives a protection key and two page-table group addresses, one primary and one secondary. It then walks the page-table entries (PTEs) one word at a time over a plain read port.

The block stops at the first entry that matches. From that entry it returns the real address, the read and write permissions and a fault code. It also writes the entry's second word back whenever the referenced or changed bit has to be set. Direct-store segments are not translated and only report a fault. One request is handled at a time: the request is taken while `busy` is low, and the result is valid during the single cycle that `done` is high.

Top module: `hpt_walker`

## Requirements
- R1: The protection key is 1 when the user flag is set and segment bit 29 is set, or when the user flag is clear and segment bit 30 is set. In every other case the key is 0.
- R2: A request whose segment bit 31 is set finishes with fault code 4, a zero real address and no permissions. It makes no memory access.
- R3: An instruction fetch from a segment whose bit 28 is set finishes with fault code 3 and makes no memory access. The same segment is translated normally for data accesses.
- R4: The block builds the group addresses from the following values:
  - The page index is EA[27:12] and the segment identifier is segment bits 23:0.
  - The primary hash is ((identifier XOR page index) AND 0x7FFFF) << 6.
  - The secondary hash is (NOT primary hash) AND 0x01FFFFC0.
  - The mask is (table bits 8:0 << 16) OR 0xFFC0.
  - Each group address is (table AND 0xFFFF0000) OR (hash AND mask).
- R5: The block reads the entries of a group in slot order 0 to 7. For slot s it reads the word at group+8s and then the word at group+8s+4. It scans the secondary group only after a full primary scan has found no match.
- R6: An entry matches when all three of these hold:
  - Word 0 bit 31 is set.
  - Word 0 bit 6 equals the pass (0 for primary, 1 for secondary).
  - Word 0 AND 0x7FFFFFBF equals (identifier << 7) OR (page index >> 10).
- R7: The scan ends at the first matching entry. No entry after it is read.
- R8: The PP field is word 1 bits 1:0. With key 0, read is always allowed and write is allowed unless PP is 3. With key 1, PP 0 allows nothing, PP 1 and PP 3 allow read only, and PP 2 allows read and write. A fetch counts as a read.
- R9: On a match, the block sets the referenced bit (0x100) of word 1. It sets the changed bit (0x80) only for a permitted write. It writes word 1 back to its own address only if its value changed.
- R10: The returned write permission is cleared whenever the changed bit of the updated word 1 is clear.
- R11: The fault code is 0 for a permitted access, 2 for a match whose access is not permitted, and 1 when neither group holds a match. The real address is {word1[31:12], EA[11:0]} on a match and 0 on a miss.
- R12: `done` is high for exactly one cycle per request. While `busy` is low the block makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a translation; taken while busy is low |
| req_ea | input | 32 | Effective address |
| req_seg | input | 32 | Segment register value selected by EA[31:28] |
| req_tbl | input | 32 | Page-table origin and size register |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access runs at user privilege |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle result strobe |
| rsp_raddr | output | 32 | Real address |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_fault | output | 3 | Fault code (0 none, 1 miss, 2 protection, 3 no-execute, 4 direct-store) |
| mem_rd_en | output | 1 | Read strobe; data is returned on the next cycle |
| mem_addr | output | 32 | Byte address of the read or write |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd_en |
| mem_wr_en | output | 1 | Write-back strobe |
| mem_wdata | output | 32 | Updated PTE word 1 |

## Verification
The assertions check the following properties on every cycle:
- Reads and write-backs never coincide, and every read is word-aligned.
- A write-back always carries the referenced bit and is followed by `done`.
- Direct-store and no-execute requests complete on the next cycle with their fault codes.
- A granted write permission never comes with a fault.
- `done` lasts one cycle, and nothing touches memory while idle.

Other behaviour needs the bench's memory image and its reference walk: the group address arithmetic, secondary-pass entry, first-match ordering, key and PP decoding, and whether a write-back is skipped. The reference walk also predicts the exact sequence of read addresses, and each read is checked against it as it happens.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_MISS   = 3'd1,
      FLT_PROT   = 3'd2,
      FLT_NOEXEC = 3'd3,
      FLT_DSTORE = 3'd4
   } fault_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD0,
      ST_RD1,
      ST_EVAL,
      ST_WB,
      ST_DONE
   } walk_st_e;

   localparam int SEG_DSTORE_BIT = 31;
   localparam int SEG_KP_BIT     = 30;
   localparam int SEG_KS_BIT     = 29;
   localparam int SEG_NOEX_BIT   = 28;
   localparam int PTE_BYTES      = 8;
   localparam logic [31:0] REF_BIT = 32'h0000_0100;
   localparam logic [31:0] CHG_BIT = 32'h0000_0080;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
   parameter int HASH_W    = 19,
   parameter int GRP_SHIFT = 6
) (
   input  logic [31:0]       ea,
   input  logic [31:0]       seg,
   input  logic [31:0]       tbl,
   output logic [1:0][31:0]  grp_addr,
   output logic [31:0]       cmp_word
);
   localparam logic [31:0] HASH_LOW  = (32'd1 << HASH_W) - 32'd1;
   localparam logic [31:0] FIELD     = HASH_LOW << GRP_SHIFT;
   localparam logic [31:0] LOW_MASK  = 32'h0000_FFFF & ~((32'd1 << GRP_SHIFT) - 32'd1);

   logic [23:0]      vsid;
   logic [15:0]      pidx;
   logic [31:0]      mixed;
   logic [31:0]      tbl_mask;
   logic [1:0][31:0] hash;

   always_comb begin
      vsid     = seg[23:0];
      pidx     = ea[27:12];
      mixed    = {8'h00, vsid ^ {8'h00, pidx}};
      hash[0]  = (mixed & HASH_LOW) << GRP_SHIFT;
      hash[1]  = ~hash[0] & FIELD;
      tbl_mask = {7'b0, tbl[8:0], 16'h0000} | LOW_MASK;
      cmp_word = {1'b0, vsid, 1'b0, pidx[15:10]};
   end

   for (genvar p = 0; p < 2; p++) begin : g_grp
      assign grp_addr[p] = {tbl[31:16], 16'h0000} | (hash[p] & tbl_mask);
   end

endmodule

// File: rtl/hpt_pte_eval.sv
module hpt_pte_eval
   import hpt_pkg::*;
(
   input  logic [31:0] w0,
   input  logic [31:0] w1,
   input  logic [31:0] cmp_word,
   input  logic        pass,
   input  logic        key,
   input  logic        is_write,
   output logic        hit,
   output logic        allow,
   output logic        perm_rd,
   output logic        perm_wr,
   output logic [31:0] w1_new,
   output logic        w1_dirty
);
   localparam logic [31:0] CMP_MASK = 32'h7FFF_FFBF;

   logic [1:0] pp;
   logic       can_rd;
   logic       can_wr;

   always_comb begin
      hit = w0[31] && (w0[6] == pass) && ((w0 & CMP_MASK) == cmp_word);
      pp  = w1[1:0];
      if (!key) begin
         can_rd = 1'b1;
         can_wr = (pp != 2'd3);
      end else begin
         can_rd = (pp != 2'd0);
         can_wr = (pp == 2'd2);
      end
      allow    = is_write ? can_wr : can_rd;
      w1_new   = w1 | REF_BIT | ((is_write && allow) ? CHG_BIT : 32'h0);
      w1_dirty = (w1_new != w1);
      perm_rd  = can_rd;
      perm_wr  = can_wr && ((w1_new & CHG_BIT) != 32'h0);
   end

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
   import hpt_pkg::*;
#(
   parameter int GROUP_PTES = 8,
   parameter int HASH_W     = 19
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [31:0] req_ea,
   input  logic [31:0] req_seg,
   input  logic [31:0] req_tbl,
   input  logic        req_write,
   input  logic        req_fetch,
   input  logic        req_user,
   output logic        busy,
   output logic        done,
   output logic [31:0] rsp_raddr,
   output logic        rsp_rd_ok,
   output logic        rsp_wr_ok,
   output logic [2:0]  rsp_fault,
   output logic        mem_rd_en,
   output logic [31:0] mem_addr,
   input  logic [31:0] mem_rdata,
   output logic        mem_wr_en,
   output logic [31:0] mem_wdata
);
   localparam int SLOT_W    = $clog2(GROUP_PTES);
   localparam int GRP_SHIFT = $clog2(GROUP_PTES * PTE_BYTES);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_PTES - 1);

   if (GROUP_PTES < 2 || (GROUP_PTES & (GROUP_PTES - 1)) != 0) begin : g_bad_group
      $error("GROUP_PTES must be a power of two of at least 2");
   end
   if (GRP_SHIFT > 16 || HASH_W + GRP_SHIFT > 32) begin : g_bad_hash
      $error("hash field does not fit the group address");
   end

   walk_st_e          st;
   logic [31:0]       ea_q, seg_q, tbl_q, w0_q, wb_q;
   logic              wr_q, user_q, pass_q;
   logic [SLOT_W-1:0] slot_q;

   logic [1:0][31:0]  grp_addr;
   logic [31:0]       cmp_word;
   logic [31:0]       pte_addr;
   logic              key;
   logic              hit, allow, perm_rd, perm_wr, w1_dirty;
   logic [31:0]       w1_new;

   hpt_hash #(.HASH_W(HASH_W), .GRP_SHIFT(GRP_SHIFT)) u_hash (
      .ea       (ea_q),
      .seg      (seg_q),
      .tbl      (tbl_q),
      .grp_addr (grp_addr),
      .cmp_word (cmp_word)
   );

   assign key = user_q ? seg_q[SEG_KS_BIT] : seg_q[SEG_KP_BIT];

   hpt_pte_eval u_eval (
      .w0       (w0_q),
      .w1       (mem_rdata),
      .cmp_word (cmp_word),
      .pass     (pass_q),
      .key      (key),
      .is_write (wr_q),
      .hit      (hit),
      .allow    (allow),
      .perm_rd  (perm_rd),
      .perm_wr  (perm_wr),
      .w1_new   (w1_new),
      .w1_dirty (w1_dirty)
   );

   assign pte_addr  = grp_addr[pass_q] + (32'(slot_q) << 3);
   assign mem_rd_en = (st == ST_RD0) || (st == ST_RD1);
   assign mem_wr_en = (st == ST_WB);
   assign mem_addr  = ((st == ST_RD1) || (st == ST_WB)) ? pte_addr + 32'd4 : pte_addr;
   assign mem_wdata = wb_q;
   assign busy      = (st != ST_IDLE);
   assign done      = (st == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ea_q      <= '0;
         seg_q     <= '0;
         tbl_q     <= '0;
         w0_q      <= '0;
         wb_q      <= '0;
         wr_q      <= 1'b0;
         user_q    <= 1'b0;
         pass_q    <= 1'b0;
         slot_q    <= '0;
         rsp_raddr <= '0;
         rsp_rd_ok <= 1'b0;
         rsp_wr_ok <= 1'b0;
         rsp_fault <= FLT_NONE;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  ea_q   <= req_ea;
                  seg_q  <= req_seg;
                  tbl_q  <= req_tbl;
                  wr_q   <= req_write;
                  user_q <= req_user;
                  pass_q <= 1'b0;
                  slot_q <= '0;
                  if (req_seg[SEG_DSTORE_BIT]) begin
                     rsp_raddr <= '0;
                     rsp_rd_ok <= 1'b0;
                     rsp_wr_ok <= 1'b0;
                     rsp_fault <= FLT_DSTORE;
                     st        <= ST_DONE;
                  end else if (req_fetch && req_seg[SEG_NOEX_BIT]) begin
                     rsp_raddr <= '0;
                     rsp_rd_ok <= 1'b0;
                     rsp_wr_ok <= 1'b0;
                     rsp_fault <= FLT_NOEXEC;
                     st        <= ST_DONE;
                  end else begin
                     st <= ST_RD0;
                  end
               end
            end
            ST_RD0: st <= ST_RD1;
            ST_RD1: begin
               w0_q <= mem_rdata;
               st   <= ST_EVAL;
            end
            ST_EVAL: begin
               if (hit) begin
                  rsp_raddr <= {mem_rdata[31:12], ea_q[11:0]};
                  rsp_rd_ok <= perm_rd;
                  rsp_wr_ok <= perm_wr;
                  rsp_fault <= allow ? FLT_NONE : FLT_PROT;
                  wb_q      <= w1_new;
                  st        <= w1_dirty ? ST_WB : ST_DONE;
               end else if (slot_q == LAST_SLOT) begin
                  slot_q <= '0;
                  if (!pass_q) begin
                     pass_q <= 1'b1;
                     st     <= ST_RD0;
                  end else begin
                     rsp_raddr <= '0;
                     rsp_rd_ok <= 1'b0;
                     rsp_wr_ok <= 1'b0;
                     rsp_fault <= FLT_MISS;
                     st        <= ST_DONE;
                  end
               end else begin
                  slot_q <= slot_q + 1'b1;
                  st     <= ST_RD0;
               end
            end
            ST_WB:   st <= ST_DONE;
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [31:0] req_seg,
   input logic        req_fetch,
   input logic        busy,
   input logic        done,
   input logic [2:0]  rsp_fault,
   input logic        rsp_rd_ok,
   input logic        rsp_wr_ok,
   input logic        mem_rd_en,
   input logic        mem_wr_en,
   input logic [31:0] mem_addr,
   input logic [31:0] mem_wdata
);
   p_port_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));

   p_rd_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (mem_addr[1:0] == 2'b00));

   p_wb_refbit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> mem_wdata[8]);

   p_wb_then_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |=> done);

   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd_en && !mem_wr_en));

   p_wrok_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rsp_wr_ok) |-> (rsp_fault == 3'd0 && rsp_rd_ok));

   p_dstore_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_seg[31]) |=> (done && rsp_fault == 3'd4 && !mem_rd_en));

   p_noexec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && !req_seg[31] && req_fetch && req_seg[28])
      |=> (done && rsp_fault == 3'd3 && !mem_rd_en));

endmodule

bind hpt_walker hpt_walker_chk u_chk (.*);

// File: tb/hpt_walker_test.sv
module hpt_walker_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write, req_fetch, req_user;
   logic [31:0] req_ea, req_seg, req_tbl;
   logic        busy, done, rsp_rd_ok, rsp_wr_ok, mem_rd_en, mem_wr_en;
   logic [31:0] rsp_raddr, mem_addr, mem_rdata, mem_wdata;
   logic [2:0]  rsp_fault;

   int n_tests = 0;
   int n_fail  = 0;
   int wr_count = 0;
   logic [31:0] mem [logic [31:0]];
   logic [31:0] exp_rd_q [$];
   string       cur_tag = "R5";

   always #10 clk = ~clk;

   hpt_walker uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
      .req_seg(req_seg), .req_tbl(req_tbl), .req_write(req_write),
      .req_fetch(req_fetch), .req_user(req_user), .busy(busy), .done(done),
      .rsp_raddr(rsp_raddr), .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok),
      .rsp_fault(rsp_fault), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   // memory model with one cycle read latency
   always @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      if (mem_wr_en) begin
         mem[mem_addr] = mem_wdata;
         wr_count++;
      end
   end

   // every read is compared against the predicted address sequence (R4 R5 R7)
   always @(negedge clk) begin
      if (rst_n && mem_rd_en) begin
         if (exp_rd_q.size() == 0) chk(1'b0, cur_tag, "unexpected read", mem_addr, 32'h0);
         else begin
            logic [31:0] e;
            e = exp_rd_q.pop_front();
            chk(mem_addr == e, cur_tag, "read address", mem_addr, e);
         end
      end
   end

   function automatic logic [31:0] rdm(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   function automatic logic [31:0] grp(input logic [31:0] ea, seg, tbl, input int pass);
      logic [31:0] vsid, pg, h, m;
      vsid = seg & 32'h00FF_FFFF;
      pg   = (ea >> 12) & 32'hFFFF;
      h    = ((vsid ^ pg) & 32'h7FFFF) << 6;
      if (pass == 1) h = ~h & 32'h01FF_FFC0;
      m    = ((tbl & 32'h1FF) << 16) | 32'hFFC0;
      return (tbl & 32'hFFFF_0000) | (h & m);
   endfunction

   function automatic logic [31:0] mk_w0(input logic [31:0] ea, seg, input bit h, input bit v);
      return ({v, 31'h0}) | ((seg & 32'h00FF_FFFF) << 7) | ({31'h0, h} << 6)
             | ((ea >> 22) & 32'h3F);
   endfunction

   task automatic put(input logic [31:0] ea, seg, tbl, input int pass, input int slot,
                      input logic [31:0] w0, input logic [31:0] w1);
      logic [31:0] a;
      a = grp(ea, seg, tbl, pass) + slot * 8;
      mem[a]     = w0;
      mem[a + 4] = w1;
   endtask

   task automatic ref_walk(input logic [31:0] ea, seg, tbl, input bit wr, fetch, user,
                           output logic [2:0] f, output logic [31:0] ra,
                           output bit rdok, output bit wrok, output bit wb,
                           output logic [31:0] wba, output logic [31:0] wbd);
      bit key, r, w, ok;
      logic [31:0] cmp, a, w0, w1, nw;
      f = 0; ra = 0; rdok = 0; wrok = 0; wb = 0; wba = 0; wbd = 0;
      if (seg[31]) begin f = 4; return; end
      if (fetch && seg[28]) begin f = 3; return; end
      key = user ? seg[29] : seg[30];
      cmp = ((seg & 32'h00FF_FFFF) << 7) | ((ea >> 22) & 32'h3F);
      for (int pass = 0; pass < 2; pass++) begin
         for (int slot = 0; slot < 8; slot++) begin
            a = grp(ea, seg, tbl, pass) + slot * 8;
            exp_rd_q.push_back(a);
            exp_rd_q.push_back(a + 4);
            w0 = rdm(a);
            w1 = rdm(a + 4);
            if (w0[31] && (w0[6] == pass[0]) && ((w0 & 32'h7FFF_FFBF) == cmp)) begin
               if (!key) begin r = 1; w = (w1[1:0] != 2'd3); end
               else begin r = (w1[1:0] != 2'd0); w = (w1[1:0] == 2'd2); end
               ok = wr ? w : r;
               nw = w1 | 32'h100;
               if (wr && ok) nw = nw | 32'h80;
               ra   = {w1[31:12], ea[11:0]};
               rdok = r;
               wrok = w && nw[7];
               f    = ok ? 3'd0 : 3'd2;
               wb   = (nw != w1);
               wba  = a + 4;
               wbd  = nw;
               return;
            end
         end
      end
      f = 1;
   endtask

   task automatic run(input string tag, input logic [31:0] ea, seg, tbl,
                      input bit wr, input bit fetch, input bit user);
      logic [2:0]  f;
      logic [31:0] ra, wba, wbd;
      bit          rdok, wrok, wb;
      int          w_before, n;
      cur_tag = tag;
      exp_rd_q.delete();
      ref_walk(ea, seg, tbl, wr, fetch, user, f, ra, rdok, wrok, wb, wba, wbd);
      w_before = wr_count;
      @(negedge clk);
      req_ea = ea; req_seg = seg; req_tbl = tbl;
      req_write = wr; req_fetch = fetch; req_user = user;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!done && n < 400) begin
         @(negedge clk);
         n++;
      end
      chk(done, tag, "done seen", {31'h0, done}, 32'h1);
      chk(rsp_fault == f, tag, "fault code", {29'h0, rsp_fault}, {29'h0, f});
      chk(rsp_raddr == ra, tag, "real address", rsp_raddr, ra);
      chk(rsp_rd_ok == rdok, tag, "read perm", {31'h0, rsp_rd_ok}, {31'h0, rdok});
      chk(rsp_wr_ok == wrok, tag, "write perm", {31'h0, rsp_wr_ok}, {31'h0, wrok});
      chk(exp_rd_q.size() == 0, tag, "reads left", exp_rd_q.size(), 32'h0);
      chk((wr_count - w_before) == int'(wb), tag, "write-back count",
          wr_count - w_before, {31'h0, wb});
      if (wb) chk(rdm(wba) == wbd, tag, "written word1", rdm(wba), wbd);
      @(negedge clk);
      chk(!done, tag, "done single cycle", {31'h0, done}, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] EA, SG, TB, TB2, EA2, SG2;
      EA  = 32'h3456_7ABC; SG = 32'h0000_0123;
      TB  = 32'h0010_0000; TB2 = 32'h0020_0003;
      EA2 = 32'h7000_5004; SG2 = 32'h000A_BCDE;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_fetch = 1'b0;
      req_user = 1'b0; req_ea = '0; req_seg = '0; req_tbl = '0;
      repeat (3) @(negedge clk);
      chk(!busy && !done, "R12", "reset idle", {30'h0, busy, done}, 32'h0);
      chk(!mem_rd_en && !mem_wr_en, "R12", "reset quiet", {30'h0, mem_rd_en, mem_wr_en}, 32'h0);
      chk(rsp_fault == 3'd0, "R11", "reset fault", {29'h0, rsp_fault}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // primary hit, read, R clear: R set, write withheld
      mem.delete();
      put(EA, SG, TB, 0, 3, mk_w0(EA, SG, 0, 1), 32'h0ABC_D002);
      run("R4_R9_R10", EA, SG, TB, 0, 0, 0);
      // permitted write sets C
      run("R9_R10_w", EA, SG, TB, 1, 0, 0);
      // R and C already set: no write-back
      run("R9_nowb", EA, SG, TB, 0, 0, 0);

      // secondary pass with decoy in primary, table size bits nonzero
      mem.delete();
      put(EA, SG, TB2, 0, 0, mk_w0(EA, SG, 1, 1), 32'h0111_1002);
      put(EA, SG, TB2, 1, 5, mk_w0(EA, SG, 1, 1), 32'h0077_7001);
      run("R5_R6_sec", EA, SG, TB2, 0, 0, 0);

      // miss in both groups
      mem.delete();
      run("R11_miss", EA, SG, TB, 0, 0, 0);

      // key 1 from Ks in user mode, PP 0 read denied
      mem.delete();
      put(EA, SG | 32'h2000_0000, TB, 0, 1, mk_w0(EA, SG, 0, 1), 32'h0555_5000);
      run("R1_R8_R11_prot", EA, SG | 32'h2000_0000, TB, 0, 0, 1);
      // key 1 from Kp in supervisor, PP 1 write denied
      mem.delete();
      put(EA, SG | 32'h4000_0000, TB, 0, 2, mk_w0(EA, SG, 0, 1), 32'h0555_5001);
      run("R1_R8_kp", EA, SG | 32'h4000_0000, TB, 1, 0, 0);
      // key 1, PP 2 write allowed
      mem.delete();
      put(EA, SG | 32'h2000_0000, TB, 0, 7, mk_w0(EA, SG, 0, 1), 32'h0666_6002);
      run("R8_k1pp2", EA, SG | 32'h2000_0000, TB, 1, 0, 1);
      // key 0 PP 3: write denied, read allowed
      mem.delete();
      put(EA, SG, TB, 0, 4, mk_w0(EA, SG, 0, 1), 32'h0444_4003);
      run("R8_pp3w", EA, SG, TB, 1, 0, 0);
      run("R8_pp3r", EA, SG, TB, 0, 0, 0);
      // user mode with only Kp set: key 0, PP 0 read allowed
      mem.delete();
      put(EA, SG | 32'h4000_0000, TB, 0, 0, mk_w0(EA, SG, 0, 1), 32'h0333_3000);
      run("R1_user_kp", EA, SG | 32'h4000_0000, TB, 0, 0, 1);

      // direct-store and no-execute
      run("R2_dstore", EA, SG | 32'h8000_0000, TB, 0, 0, 0);
      mem.delete();
      put(EA, SG | 32'h1000_0000, TB, 0, 6, mk_w0(EA, SG, 0, 1), 32'h0222_2002);
      run("R3_noexec", EA, SG | 32'h1000_0000, TB, 0, 1, 0);
      run("R3_data_ok", EA, SG | 32'h1000_0000, TB, 0, 0, 0);

      // first match wins
      mem.delete();
      put(EA2, SG2, TB, 0, 2, mk_w0(EA2, SG2, 0, 1), 32'h0AAA_A102);
      put(EA2, SG2, TB, 0, 4, mk_w0(EA2, SG2, 0, 1), 32'h0BBB_B102);
      run("R7_first", EA2, SG2, TB, 0, 0, 0);

      // invalid and wrong-identifier entries are skipped
      mem.delete();
      put(EA2, SG2, TB, 0, 0, mk_w0(EA2, SG2 ^ 32'h1, 0, 1), 32'h0CCC_C002);
      put(EA2, SG2, TB, 0, 1, mk_w0(EA2, SG2, 0, 0), 32'h0DDD_D002);
      put(EA2, SG2, TB, 0, 6, mk_w0(EA2, SG2, 0, 1), 32'h0EEE_E002);
      run("R6_skip", EA2, SG2, TB, 1, 0, 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule